// File: doc/BRIEF.md
# Synthesizer Programming Port over a Two-Wire Bus

This block is a write-only I2C slave that lets a bus controller program a frequency synthesizer. It watches the two bus lines, detects START and STOP, compares the address byte against a fixed five-bit prefix plus two strap pins, and acknowledges a matching write. It then steps through the data bytes of the transaction in a fixed order. Each byte lands in the output register it belongs to: the 15-bit divider ratio, the group of synthesizer control fields, or the 8-bit port word.

Bit 7 of the first data byte decides where a transaction begins. A 0 starts at the upper divider byte and a 1 starts at the setup byte, so one transfer can rewrite everything, or only the divider, or only the setup and port values. The upper divider bits are held in a shadow register. The divider output changes only when the lower byte completes, so the ratio never takes on a half-written value. Four instances with different strap settings can share one bus.

Top module: `synth_ctrl_i2c`

## Requirements
- R1: The address byte is acknowledged only when its bits 7:3 equal 11000, its bits 2:1 equal `addr_sel[1:0]`, and bit 0 (read/write, 0 = write) is 0. A byte that does not match, including a read address, gets no acknowledge, and every later byte up to the next START or STOP is neither acknowledged nor stored.
- R2: In an acknowledged write, the block pulls SDA low (`sda_oe` = 1) for the whole ninth SCL pulse of the address byte and of every data byte. It asserts `sda_oe` only while SCL is low, and it releases it on the SCL fall that ends the ninth pulse.
- R3: Bit 7 of the first data byte after the address chooses the starting byte. A 0 means the upper divider byte and a 1 means the setup byte.
- R4: The upper divider byte supplies its bits 6:0 as ratio bits 14:8, and the lower divider byte supplies ratio bits 7:0. `div_ratio` changes only when the lower byte completes, never after the upper byte alone.
- R5: The setup byte maps as follows: bit 6 goes to `cp_high`, bits 5:3 to `test_bits[2:0]`, bit 2 to `ref_sel[1]`, bit 1 to `ref_sel[0]`, and bit 0 to `tune_off`. Bit 7 is not stored. All five fields load together when the byte completes.
- R6: The port byte loads into `port_out[7:0]` bit for bit when it completes.
- R7: From a divider start the byte order is upper divider, lower divider, setup, port. From a setup start it is setup, port, upper divider, lower divider. At most one register loads per byte.
- R8: Data bytes beyond the fourth in one transaction are acknowledged but change no output.
- R9: A STOP or a repeated START returns the sequencer to its first-byte state. An upper divider byte that no lower byte has followed is then dropped, and the bus event releases SDA.
- R10: After reset, `div_ratio` is 0, `port_out` is 0, `cp_high` is 0, `ref_sel` is 00, `test_bits` is 001 and `tune_off` is 0.
- R11: A register output takes its new value exactly four `clk` cycles after the eighth SCL rise of its byte appears at the pins: two synchroniser stages, one edge-detect and byte stage, and one register load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock line, asynchronous |
| sda_in | input | 1 | Bus data line as seen on the wire, asynchronous |
| addr_sel | input | 2 | Strap bits compared with address bits 2:1 |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain acknowledge) |
| div_ratio | output | 15 | Committed divider ratio |
| cp_high | output | 1 | Charge-pump current select |
| test_bits | output | 3 | Test mode field |
| ref_sel | output | 2 | Reference divider ratio select |
| tune_off | output | 1 | 1 turns the tuning output off |
| port_out | output | 8 | Port switch word, 1 = on |

## Verification
Each register output is due exactly four clock cycles after the bench raises SCL for the eighth bit of its byte. The bench keeps its model in transaction time and feeds each cycle's snapshot through a three-deep queue clocked on the rising edge. It compares all three outputs against the head of that queue on every falling edge, so a result that comes one cycle early or late is reported. The acknowledge comes through two synchroniser stages and one more register, and the bench samples it three cycles into the ninth SCL high phase, well after it has settled.

// File: rtl/synth_i2c_pkg.sv
package synth_i2c_pkg;
  localparam int BYTE_W = 8;
  localparam int SETUP_W = 7;

  typedef enum logic [2:0] {
    K_DIV_HI, K_DIV_LO, K_SETUP, K_PORT, K_NONE
  } byte_kind_e;

  typedef struct packed {
    logic       cp;
    logic [2:0] test;
    logic [1:0] refsel;
    logic       tune_off;
  } setup_t;

  localparam setup_t SETUP_RST = '{cp: 1'b0, test: 3'b001, refsel: 2'b00, tune_off: 1'b0};

  // slot of a byte in the transaction: the setup-first order is the
  // divider-first order rotated by two positions
  function automatic byte_kind_e kind_at(input logic setup_first, input logic [2:0] idx);
    logic [1:0] slot;
    if (idx > 3'd3) return K_NONE;
    slot = idx[1:0] + (setup_first ? 2'd2 : 2'd0);
    case (slot)
      2'd0:    return K_DIV_HI;
      2'd1:    return K_DIV_LO;
      2'd2:    return K_SETUP;
      default: return K_PORT;
    endcase
  endfunction

  function automatic logic addr_hit(input logic [7:0] b, input logic [1:0] sel,
                                    input logic [4:0] fixed);
    return (b[7:3] == fixed) && (b[2:1] == sel) && !b[0];
  endfunction

  function automatic logic [14:0] join_div(input logic [6:0] hi, input logic [7:0] lo);
    return {hi, lo};
  endfunction

  function automatic setup_t unpack_setup(input logic [7:0] b);
    return setup_t'(b[6:0]);
  endfunction
endpackage

// File: rtl/i2c_pin_sync.sv
module i2c_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      scl_q  <= scl_s;
      sda_q  <= sda_s;
    end
  end

  assign scl_s     = scl_ff[STAGES-1];
  assign sda_s     = sda_ff[STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_evt = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_evt  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2c_byte_rx.sv
module i2c_byte_rx
  import synth_i2c_pkg::*;
#(
  parameter logic [4:0] ADDR_FIXED = 5'b11000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_evt,
  input  logic              stop_evt,
  input  logic [1:0]        addr_sel,
  output logic              data_valid,
  output logic [BYTE_W-1:0] data_byte,
  output logic              sda_oe
);
  localparam int CNT_W = $clog2(BYTE_W + 2);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] ACK_SLOT = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] ACK_HIGH = CNT_W'(BYTE_W + 1);

  typedef enum logic [1:0] {S_IDLE, S_ADDR, S_DATA, S_SKIP} rx_state_e;

  rx_state_e         state;
  logic [BYTE_W-1:0] shreg;
  logic [CNT_W-1:0]  bit_cnt;
  logic              ack_pend;
  logic [BYTE_W-1:0] full_byte;
  logic              byte_end;

  assign full_byte = {shreg[BYTE_W-2:0], sda_s};
  assign byte_end  = scl_rise && (bit_cnt == LAST_BIT) && (state != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      shreg      <= '0;
      bit_cnt    <= '0;
      ack_pend   <= 1'b0;
      sda_oe     <= 1'b0;
      data_valid <= 1'b0;
      data_byte  <= '0;
    end else begin
      data_valid <= 1'b0;
      if (start_evt || stop_evt) begin
        state    <= start_evt ? S_ADDR : S_IDLE;
        bit_cnt  <= '0;
        ack_pend <= 1'b0;
        sda_oe   <= 1'b0;
      end else if (state != S_IDLE) begin
        if (scl_rise) begin
          if (bit_cnt < ACK_SLOT) begin
            shreg   <= full_byte;
            bit_cnt <= bit_cnt + 1'b1;
          end else if (bit_cnt == ACK_SLOT) begin
            bit_cnt <= ACK_HIGH;
          end
        end
        if (scl_fall) begin
          if (bit_cnt == ACK_SLOT && ack_pend) begin
            sda_oe   <= 1'b1;
            ack_pend <= 1'b0;
          end else if (bit_cnt == ACK_HIGH) begin
            sda_oe  <= 1'b0;
            bit_cnt <= '0;
          end
        end
        if (byte_end) begin
          unique case (state)
            S_ADDR: begin
              if (addr_hit(full_byte, addr_sel, ADDR_FIXED)) begin
                ack_pend <= 1'b1;
                state    <= S_DATA;
              end else begin
                state <= S_SKIP;
              end
            end
            S_DATA: begin
              ack_pend   <= 1'b1;
              data_valid <= 1'b1;
              data_byte  <= full_byte;
            end
            default: ;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/synth_reg_bank.sv
module synth_reg_bank
  import synth_i2c_pkg::*;
#(
  parameter int DIV_W  = 15,
  parameter int PORT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              seq_clear,
  input  logic              data_valid,
  input  logic [BYTE_W-1:0] data_byte,
  output logic [DIV_W-1:0]  div_ratio,
  output setup_t            setup_q,
  output logic [PORT_W-1:0] port_q,
  output logic              div_commit,
  output logic              setup_commit,
  output logic              port_commit
);
  localparam int HI_W = DIV_W - BYTE_W;

  logic [2:0]      idx;
  logic            setup_first;
  logic [HI_W-1:0] hi_shadow;
  byte_kind_e      cur_kind;

  always_comb begin
    if (idx == 3'd0) cur_kind = data_byte[BYTE_W-1] ? K_SETUP : K_DIV_HI;
    else             cur_kind = kind_at(setup_first, idx);
  end

  assign div_commit   = data_valid && (cur_kind == K_DIV_LO);
  assign setup_commit = data_valid && (cur_kind == K_SETUP);
  assign port_commit  = data_valid && (cur_kind == K_PORT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx         <= '0;
      setup_first <= 1'b0;
      hi_shadow   <= '0;
      div_ratio   <= '0;
      setup_q     <= SETUP_RST;
      port_q      <= '0;
    end else if (seq_clear) begin
      idx <= '0;
    end else if (data_valid) begin
      if (idx == 3'd0) setup_first <= data_byte[BYTE_W-1];
      if (idx < 3'd4) idx <= idx + 1'b1;
      if (cur_kind == K_DIV_HI) hi_shadow <= data_byte[HI_W-1:0];
      if (div_commit) div_ratio <= join_div(hi_shadow, data_byte);
      if (setup_commit) setup_q <= unpack_setup(data_byte);
      if (port_commit) port_q <= data_byte[PORT_W-1:0];
    end
  end
endmodule

// File: rtl/synth_ctrl_i2c.sv
module synth_ctrl_i2c
  import synth_i2c_pkg::*;
#(
  parameter logic [4:0] ADDR_FIXED  = 5'b11000,
  parameter int         SYNC_STAGES = 2,
  parameter int         DIV_W       = 15,
  parameter int         PORT_W      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_in,
  input  logic              sda_in,
  input  logic [1:0]        addr_sel,
  output logic              sda_oe,
  output logic [DIV_W-1:0]  div_ratio,
  output logic              cp_high,
  output logic [2:0]        test_bits,
  output logic [1:0]        ref_sel,
  output logic              tune_off,
  output logic [PORT_W-1:0] port_out
);
  logic scl_s, sda_s, scl_rise, scl_fall;
  logic evt_start, evt_stop, evt_data_byte;
  logic evt_div_commit, evt_setup_commit, evt_port_commit;
  logic [BYTE_W-1:0] rx_byte;
  setup_t setup_q;
  logic [SETUP_W-1:0] setup_bits;

  i2c_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_in), .sda_i(sda_in),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(evt_start), .stop_evt(evt_stop)
  );

  i2c_byte_rx #(.ADDR_FIXED(ADDR_FIXED)) u_rx (
    .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_evt(evt_start), .stop_evt(evt_stop),
    .addr_sel(addr_sel), .data_valid(evt_data_byte), .data_byte(rx_byte),
    .sda_oe(sda_oe)
  );

  synth_reg_bank #(.DIV_W(DIV_W), .PORT_W(PORT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .seq_clear(evt_start | evt_stop),
    .data_valid(evt_data_byte), .data_byte(rx_byte),
    .div_ratio(div_ratio), .setup_q(setup_q), .port_q(port_out),
    .div_commit(evt_div_commit), .setup_commit(evt_setup_commit),
    .port_commit(evt_port_commit)
  );

  assign cp_high    = setup_q.cp;
  assign test_bits  = setup_q.test;
  assign ref_sel    = setup_q.refsel;
  assign tune_off   = setup_q.tune_off;
  assign setup_bits = setup_q;
endmodule

// File: rtl/synth_ctrl_i2c_chk.sv
module synth_ctrl_i2c_chk #(
  parameter int DIV_W  = 15,
  parameter int PORT_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sda_oe,
  input logic              scl_s,
  input logic              evt_start,
  input logic              evt_stop,
  input logic              evt_div_commit,
  input logic              evt_setup_commit,
  input logic              evt_port_commit,
  input logic [DIV_W-1:0]  div_ratio,
  input logic [6:0]        setup_bits,
  input logic [PORT_W-1:0] port_out
);
  assert_div_commit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(div_ratio) |-> $past(evt_div_commit));

  assert_setup_commit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(setup_bits) |-> $past(evt_setup_commit));

  assert_port_commit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(port_out) |-> $past(evt_port_commit));

  assert_one_commit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({evt_div_commit, evt_setup_commit, evt_port_commit}));

  assert_ack_scl_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s);

  assert_release_on_bus_evt_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_start || evt_stop) |=> !sda_oe);

  assert_no_commit_on_bus_evt_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_start || evt_stop) |-> !(evt_div_commit || evt_setup_commit || evt_port_commit));
endmodule

bind synth_ctrl_i2c synth_ctrl_i2c_chk #(.DIV_W(DIV_W), .PORT_W(PORT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe), .scl_s(scl_s),
  .evt_start(evt_start), .evt_stop(evt_stop),
  .evt_div_commit(evt_div_commit), .evt_setup_commit(evt_setup_commit),
  .evt_port_commit(evt_port_commit), .div_ratio(div_ratio),
  .setup_bits(setup_bits), .port_out(port_out)
);

// File: tb/synth_ctrl_i2c_test.sv
module synth_ctrl_i2c_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic [1:0] addr_sel = 2'b10;
  logic sda_oe, cp_high, tune_off;
  logic [14:0] div_ratio;
  logic [2:0] test_bits;
  logic [1:0] ref_sel;
  logic [7:0] port_out;
  wire sda_line = sda_m & ~sda_oe;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  synth_ctrl_i2c uut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda_line),
    .addr_sel(addr_sel), .sda_oe(sda_oe), .div_ratio(div_ratio),
    .cp_high(cp_high), .test_bits(test_bits), .ref_sel(ref_sel),
    .tune_off(tune_off), .port_out(port_out)
  );

  // model state, in transaction time
  logic [14:0] m_div = '0;
  logic [6:0]  m_setup = 7'b0001000;   // R10: test=001, rest 0
  logic [7:0]  m_port = '0;
  logic [6:0]  m_hi = '0;
  bit          m_addressed = 0;
  bit          m_first = 1;
  string       m_plan[$];

  // R11: model snapshot delayed by three rising edges, compared on falling edges
  logic [29:0] pipe[$];
  logic [29:0] exp_q = {15'd0, 7'b0001000, 8'd0};

  always @(posedge clk) begin
    pipe.push_back({m_div, m_setup, m_port});
    if (pipe.size() > 3) exp_q = pipe.pop_front();
  end

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(div_ratio == exp_q[29:15], "R4 R11 divider", div_ratio, exp_q[29:15]);
      chk({cp_high, test_bits, ref_sel, tune_off} == exp_q[14:8], "R5 R11 setup",
          {cp_high, test_bits, ref_sel, tune_off}, exp_q[14:8]);
      chk(port_out == exp_q[7:0], "R6 R11 port", port_out, exp_q[7:0]);
    end
  end

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; hold(6);
    scl = 1'b1; hold(6);
    sda_m = 1'b0; hold(6);
    scl = 1'b0; hold(6);
    m_first = 1; m_plan.delete();   // R9
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; hold(6);
    scl = 1'b1; hold(6);
    sda_m = 1'b1; hold(6);
    m_addressed = 0; m_first = 1; m_plan.delete();   // R9
  endtask

  // model action at the eighth rise of a data byte (R3, R4, R5, R6, R7, R8)
  task automatic model_data(input logic [7:0] b);
    string k;
    if (!m_addressed) return;
    if (m_first) begin
      m_first = 0;
      if (b[7]) m_plan = '{"set", "port", "hi", "lo"};
      else      m_plan = '{"hi", "lo", "set", "port"};
    end
    if (m_plan.size() == 0) return;   // R8
    k = m_plan.pop_front();
    if (k == "hi") m_hi = b[6:0];
    else if (k == "lo") m_div = {m_hi, b};
    else if (k == "set") m_setup = b[6:0];
    else m_port = b;
  endtask

  task automatic send_byte(input logic [7:0] b, input bit is_addr, input string tag);
    bit exp_ack;
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; hold(6);
      scl = 1'b1;
      if (i == 0) begin
        if (is_addr) m_addressed = (b[7:3] == 5'b11000) && (b[2:1] == addr_sel) && !b[0];
        else model_data(b);
      end
      hold(6);
      scl = 1'b0; hold(6);
    end
    exp_ack = m_addressed;
    sda_m = 1'b1; hold(6);
    scl = 1'b1; hold(3);
    chk(sda_oe == exp_ack, tag, sda_oe, exp_ack);
    hold(3);
    scl = 1'b0; hold(6);
  endtask

  task automatic data(input logic [7:0] b);
    send_byte(b, 0, "R2 data ack");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    hold(5);
    rst_n = 1'b1;
    hold(2);
    // R10 reset values
    chk(div_ratio == 0, "R10 divider", div_ratio, 0);
    chk(test_bits == 3'b001, "R10 test bits", test_bits, 1);
    chk({cp_high, ref_sel, tune_off} == 0, "R10 other setup", {cp_high, ref_sel, tune_off}, 0);
    chk(port_out == 0, "R10 port", port_out, 0);

    // R1 R3 R7: full write, divider first
    bus_start();
    send_byte(8'hC4, 1, "R1 addr ack");
    data(8'h2A); data(8'h5C); data(8'hCB); data(8'hA5);
    bus_stop(); hold(8);
    chk(div_ratio == 15'h2A5C, "R4 full divider", div_ratio, 15'h2A5C);
    chk({cp_high, test_bits, ref_sel, tune_off} == 7'h4B, "R5 setup map",
        {cp_high, test_bits, ref_sel, tune_off}, 7'h4B);
    chk(port_out == 8'hA5, "R6 port", port_out, 8'hA5);

    // R3 R7 R8: setup first, then port, divider, extra bytes
    bus_start();
    send_byte(8'hC4, 1, "R1 addr ack");
    data(8'hB4);
    data(8'h3C);
    hold(8);
    chk(port_out == 8'h3C, "R7 port after setup", port_out, 8'h3C);
    data(8'hFF); data(8'h01);
    data(8'h77); data(8'h00);
    bus_stop(); hold(8);
    chk(div_ratio == 15'h7F01, "R7 divider after port", div_ratio, 15'h7F01);
    chk(port_out == 8'h3C, "R8 extra bytes ignored", port_out, 8'h3C);

    // R1 wrong strap bits: no ack, no change
    bus_start();
    send_byte(8'hC2, 1, "R1 strap mismatch nack");
    data(8'h00); data(8'h11);
    bus_stop();
    // R1 read mode not acknowledged
    bus_start();
    send_byte(8'hC5, 1, "R1 read nack");
    bus_stop();
    // R1 wrong fixed prefix
    bus_start();
    send_byte(8'h44, 1, "R1 prefix nack");
    data(8'h80);
    bus_stop(); hold(8);
    chk(div_ratio == 15'h7F01, "R1 ignored bytes", div_ratio, 15'h7F01);

    // R4 R9: upper byte alone then STOP leaves divider unchanged
    bus_start();
    send_byte(8'hC4, 1, "R1 addr ack");
    data(8'h12);
    bus_stop();
    bus_start();
    send_byte(8'hC4, 1, "R1 addr ack");
    data(8'hC0);
    bus_stop(); hold(8);
    chk(div_ratio == 15'h7F01, "R9 shadow dropped", div_ratio, 15'h7F01);

    // R9 repeated start restarts the sequence
    bus_start();
    send_byte(8'hC4, 1, "R1 addr ack");
    data(8'h11);
    bus_start();
    send_byte(8'hC4, 1, "R1 addr ack");
    data(8'h9A); data(8'h5A);
    bus_stop(); hold(8);
    chk(port_out == 8'h5A, "R9 restart reclassifies", port_out, 8'h5A);
    chk(div_ratio == 15'h7F01, "R9 restart divider", div_ratio, 15'h7F01);

    // R1 other strap setting
    addr_sel = 2'b00;
    hold(4);
    bus_start();
    send_byte(8'hC0, 1, "R1 strap 00 ack");
    data(8'h05); data(8'h06);
    bus_stop(); hold(8);
    chk(div_ratio == 15'h0506, "R4 divider strap 00", div_ratio, 15'h0506);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule